// File: doc/BRIEF.md
# Reset Sequencer with Start-up Delay

This block merges three reset causes into the single internal reset that holds the rest of a chip in its initial state. The causes are a power-on indication, an active-low reset pin that has already been brought into the clock domain, and a one-cycle time-out pulse from a watchdog. When the last active cause goes away, the internal reset is not released at once. It stays asserted for a start-up delay that a 2-bit fuse field selects. One setting counts a handful of CPU clocks. The other three settings count pulses of a slow clock enable that comes from a low-speed oscillator. A new cause that arrives during the delay starts the count again from zero.

The block also holds two sticky flags that record why the chip was last reset. A power-on sets the power-on flag and clears the pin flag. A pin reset sets the pin flag and leaves the power-on flag alone. A watchdog reset changes neither flag. The internal reset does not initialise the flags, so software can read them after start-up. Software clears either flag through a masked clear strobe. The power-on input is the only asynchronous initialisation in the block.

Top module: `rst_sequencer`

## Requirements
- R1: While `powerOnIn` is 1, `rstOut` is 1, `porFlag` is 1 and `extFlag` is 0. When it falls, the start-up delay begins on the next clock edge.
- R2: With `startSel` = 2'b00 the delay is `CpuDelay` clocks (5 by default). `rstOut` falls on the 5th rising edge after the edge that first samples every cause inactive, counting that edge as the first. `slowTick` has no effect on this delay.
- R3: With `startSel` = 2'b01, 2'b10 or 2'b11 the delay is `SlowDly1`, `SlowDly2` or `SlowDly3` pulses of `slowTick` (512, 4096 and 16384 by default). `rstOut` falls on the edge that samples the last required pulse. Clock edges with `slowTick` = 0 do not count.
- R4: While `pinRstN` is sampled 0, `rstOut` is 1 from the next edge onward and no delay progress is made. The count begins on the edge that first samples `pinRstN` = 1.
- R5: A `wdtExpire` pulse one clock long drives `rstOut` to 1 from the next edge. The delay count begins on the edge after the pulse.
- R6: An edge that samples `pinRstN` = 0 sets `extFlag` to 1 and leaves `porFlag` unchanged.
- R7: A watchdog reset leaves `porFlag` and `extFlag` unchanged. The flags change only for a power-on, a pin reset or a clear.
- R8: When `flagClr` is 1 on an edge, mask bit 0 clears `porFlag` and mask bit 1 clears `extFlag`. If a pin reset is sampled on the same edge, setting `extFlag` wins over clearing it.
- R9: A pin reset or a watchdog pulse that arrives during the delay restarts the count from zero. The full delay is then needed again.
- R10: Once released, `rstOut` stays 0 while no cause is active, whatever `slowTick` and `startSel` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| powerOnIn | input | 1 | Power-on indication, active high, asynchronous |
| pinRstN | input | 1 | Synchronised reset pin, active low |
| wdtExpire | input | 1 | Watchdog time-out, one-clock pulse |
| startSel | input | 2 | Start-up delay fuse setting |
| slowTick | input | 1 | Slow-oscillator clock enable, one pulse per slow cycle |
| flagClr | input | 1 | Cause-flag clear strobe |
| flagClrMask | input | 2 | Bit 0 selects `porFlag`, bit 1 selects `extFlag` |
| rstOut | output | 1 | Internal reset, active high |
| porFlag | output | 1 | Sticky power-on cause flag |
| extFlag | output | 1 | Sticky pin-reset cause flag |

## Verification
The release latency is measured for every delay setting crossed with slow-tick spacings of one, two and three clocks, and for both a pin reset and a watchdog pulse as the last cause. The expected value is the CPU delay for setting 00 and the selected pulse count times the spacing for the others. These runs tell a wrong count, a count that runs on plain clocks instead of ticks, and an off-by-one start edge apart from each other. In the restart runs the count is partly advanced and then interrupted, so a counter that is not cleared releases early. The flag runs set, clear and collide the sources in turn, which separates the treatment of each cause.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_COUNT = 2'd1,
    ST_RUN   = 2'd2
  } rs_state_t;

  typedef struct packed {
    logic cntClear;
    logic cntStep;
    logic setExt;
  } rs_strobe_t;

endpackage

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
(
  input  logic       clk,
  input  logic       powerOnIn,
  input  logic       pinRstN,
  input  logic       wdtExpire,
  input  logic       tickNow,
  input  logic       atLast,
  output rs_strobe_t strb,
  output logic       rstOut
);

  rs_state_t state, stateNext;
  logic causeNow;
  logic stepping;
  logic releaseNow;

  always_comb begin
    causeNow   = !pinRstN || wdtExpire;
    stepping   = !causeNow && (state != ST_RUN) && tickNow;
    releaseNow = stepping && atLast;

    strb.cntClear = causeNow || releaseNow;
    strb.cntStep  = stepping && !atLast;
    strb.setExt   = !pinRstN;

    if (causeNow)
      stateNext = ST_HOLD;
    else if (releaseNow)
      stateNext = ST_RUN;
    else if (state == ST_HOLD)
      stateNext = ST_COUNT;
    else
      stateNext = state;
  end

  always_ff @(posedge clk or posedge powerOnIn) begin
    if (powerOnIn)
      state <= ST_HOLD;
    else
      state <= stateNext;
  end

  assign rstOut = (state != ST_RUN);

  // R1: power-on keeps the internal reset asserted
  assert_por_holds_R1: assert property (@(posedge clk)
    powerOnIn |-> rstOut);

  // R4: a sampled low pin forces reset on the next cycle
  assert_pin_holds_R4: assert property (@(posedge clk) disable iff (powerOnIn)
    !pinRstN |=> rstOut);

  // R5: a watchdog pulse forces reset on the next cycle
  assert_wdt_pulse_R5: assert property (@(posedge clk) disable iff (powerOnIn)
    wdtExpire |=> rstOut);

  // R9: release never happens on an edge that sees a cause
  assert_release_clean_R9: assert property (@(posedge clk) disable iff (powerOnIn)
    $fell(rstOut) |-> ($past(pinRstN) && !$past(wdtExpire)));

  // R10: a released reset only rises again because of a cause
  assert_run_stable_R10: assert property (@(posedge clk) disable iff (powerOnIn)
    (!rstOut && pinRstN && !wdtExpire) |=> !rstOut);

endmodule

// File: rtl/rstseq_dp.sv
module rstseq_dp
  import rstseq_pkg::*;
#(
  parameter int CpuDelay = 5,
  parameter int SlowDly1 = 512,
  parameter int SlowDly2 = 4096,
  parameter int SlowDly3 = 16384
) (
  input  logic       clk,
  input  logic       powerOnIn,
  input  logic [1:0] startSel,
  input  logic       slowTick,
  input  logic       flagClr,
  input  logic [1:0] flagClrMask,
  input  rs_strobe_t strb,
  output logic       tickNow,
  output logic       atLast,
  output logic       porFlag,
  output logic       extFlag
);

  localparam int MaxA   = (CpuDelay > SlowDly1) ? CpuDelay : SlowDly1;
  localparam int MaxB   = (SlowDly2 > SlowDly3) ? SlowDly2 : SlowDly3;
  localparam int MaxDly = (MaxA > MaxB) ? MaxA : MaxB;
  localparam int CntW   = (MaxDly > 2) ? $clog2(MaxDly) : 1;

  logic [CntW-1:0] cnt;
  logic [CntW:0]   curTarget;

  always_comb begin
    unique case (startSel)
      2'b00:   curTarget = (CntW+1)'(CpuDelay);
      2'b01:   curTarget = (CntW+1)'(SlowDly1);
      2'b10:   curTarget = (CntW+1)'(SlowDly2);
      default: curTarget = (CntW+1)'(SlowDly3);
    endcase
    tickNow = (startSel == 2'b00) ? 1'b1 : slowTick;
    atLast  = ({1'b0, cnt} == curTarget - 1'b1);
  end

  always_ff @(posedge clk or posedge powerOnIn) begin
    if (powerOnIn)
      cnt <= '0;
    else if (strb.cntClear)
      cnt <= '0;
    else if (strb.cntStep)
      cnt <= cnt + 1'b1;
  end

  // cause flags: only power-on initialises them
  always_ff @(posedge clk or posedge powerOnIn) begin
    if (powerOnIn) begin
      porFlag <= 1'b1;
      extFlag <= 1'b0;
    end else begin
      if (strb.setExt)
        extFlag <= 1'b1;
      else if (flagClr && flagClrMask[1])
        extFlag <= 1'b0;
      if (flagClr && flagClrMask[0])
        porFlag <= 1'b0;
    end
  end

  // R3: the delay counter never reaches the selected length
  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (powerOnIn)
    ({1'b0, cnt} < curTarget));

  // R6: a pin reset sets the pin flag and spares the power-on flag
  assert_pin_sets_flag_R6: assert property (@(posedge clk) disable iff (powerOnIn)
    (strb.setExt && !flagClr) |=> (extFlag && $stable(porFlag)));

  // R7: without a pin reset or a clear the flags hold
  assert_flags_hold_R7: assert property (@(posedge clk) disable iff (powerOnIn)
    (!strb.setExt && !flagClr) |=> ($stable(porFlag) && $stable(extFlag)));

  // R8: a clear of the power-on flag takes effect on the next cycle
  assert_clear_por_R8: assert property (@(posedge clk) disable iff (powerOnIn)
    (flagClr && flagClrMask[0]) |=> !porFlag);

endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
  import rstseq_pkg::*;
#(
  parameter int CpuDelay = 5,
  parameter int SlowDly1 = 512,
  parameter int SlowDly2 = 4096,
  parameter int SlowDly3 = 16384
) (
  input  logic       clk,
  input  logic       powerOnIn,
  input  logic       pinRstN,
  input  logic       wdtExpire,
  input  logic [1:0] startSel,
  input  logic       slowTick,
  input  logic       flagClr,
  input  logic [1:0] flagClrMask,
  output logic       rstOut,
  output logic       porFlag,
  output logic       extFlag
);

  rs_strobe_t strb;
  logic tickNow;
  logic atLast;

  rstseq_ctrl u_ctrl (
    .clk       (clk),
    .powerOnIn (powerOnIn),
    .pinRstN   (pinRstN),
    .wdtExpire (wdtExpire),
    .tickNow   (tickNow),
    .atLast    (atLast),
    .strb      (strb),
    .rstOut    (rstOut)
  );

  rstseq_dp #(
    .CpuDelay (CpuDelay),
    .SlowDly1 (SlowDly1),
    .SlowDly2 (SlowDly2),
    .SlowDly3 (SlowDly3)
  ) u_dp (
    .clk         (clk),
    .powerOnIn   (powerOnIn),
    .startSel    (startSel),
    .slowTick    (slowTick),
    .flagClr     (flagClr),
    .flagClrMask (flagClrMask),
    .strb        (strb),
    .tickNow     (tickNow),
    .atLast      (atLast),
    .porFlag     (porFlag),
    .extFlag     (extFlag)
  );

endmodule

// File: tb/rst_sequencer_bench.sv
`timescale 1ns/1ps
module rst_sequencer_bench;

  localparam int CpuD = 5;
  localparam int D1   = 4;
  localparam int D2   = 6;
  localparam int D3   = 9;

  logic clk = 1'b0;
  logic powerOnIn, pinRstN, wdtExpire, slowTick, flagClr;
  logic [1:0] startSel, flagClrMask;
  logic rstOut, porFlag, extFlag;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rst_sequencer #(
    .CpuDelay (CpuD), .SlowDly1 (D1), .SlowDly2 (D2), .SlowDly3 (D3)
  ) u_rst_sequencer (
    .clk (clk), .powerOnIn (powerOnIn), .pinRstN (pinRstN),
    .wdtExpire (wdtExpire), .startSel (startSel), .slowTick (slowTick),
    .flagClr (flagClr), .flagClrMask (flagClrMask),
    .rstOut (rstOut), .porFlag (porFlag), .extFlag (extFlag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expLat(input int s, input int p);
    case (s)
      0: return CpuD;
      1: return D1 * p;
      2: return D2 * p;
      default: return D3 * p;
    endcase
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // cycles from release until rstOut reads low; tick every p clocks
  task automatic measure(input int p, output int lat);
    lat = -1;
    for (int k = 0; k < 200; k++) begin
      slowTick = ((k % p) == (p - 1));
      step();
      if (!rstOut) begin
        lat = k + 1;
        break;
      end
    end
    slowTick = 1'b0;
  endtask

  task automatic clearPulse(input logic [1:0] m);
    flagClr = 1'b1;
    flagClrMask = m;
    step();
    flagClr = 1'b0;
    flagClrMask = 2'b00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int lat;
    logic pf, ef;
    powerOnIn = 1'b1; pinRstN = 1'b1; wdtExpire = 1'b0; slowTick = 1'b0;
    startSel = 2'b00; flagClr = 1'b0; flagClrMask = 2'b00;
    repeat (3) @(negedge clk);
    // R1: power-on state
    chk(rstOut == 1'b1, "R1 rstOut during power-on", rstOut, 1);
    chk(porFlag == 1'b1, "R1 porFlag", porFlag, 1);
    chk(extFlag == 1'b0, "R1 extFlag", extFlag, 0);
    powerOnIn = 1'b0;
    measure(1, lat);
    chk(lat == CpuD, "R1 R2 delay after power-on", lat, CpuD);

    // R2 R3 R4 R5: sweep of settings, tick spacings and last cause
    for (int s = 0; s < 4; s++) begin
      for (int p = 1; p < 4; p++) begin
        startSel = 2'(s);
        pinRstN = 1'b0;
        step();
        chk(rstOut == 1'b1, "R4 pin low asserts reset", rstOut, 1);
        chk(extFlag == 1'b1 && porFlag == 1'b1, "R6 pin sets extFlag", {porFlag, extFlag}, 3);
        for (int j = 0; j < 3; j++) begin
          slowTick = 1'b1;
          step();
        end
        slowTick = 1'b0;
        pinRstN = 1'b1;
        measure(p, lat);
        chk(lat == expLat(s, p), (s == 0) ? "R2 pin release delay" : "R3 pin release delay",
            lat, expLat(s, p));

        pf = porFlag; ef = extFlag;
        wdtExpire = 1'b1;
        step();
        chk(rstOut == 1'b1, "R5 watchdog asserts reset", rstOut, 1);
        wdtExpire = 1'b0;
        measure(p, lat);
        chk(lat == expLat(s, p), (s == 0) ? "R2 R5 watchdog release delay" : "R3 R5 watchdog release delay",
            lat, expLat(s, p));
        chk(porFlag == pf && extFlag == ef, "R7 watchdog keeps flags",
            {porFlag, extFlag}, {pf, ef});
      end
    end

    // R9: restart by the pin during a slow count
    startSel = 2'b01;
    pinRstN = 1'b0; step();
    pinRstN = 1'b1;
    slowTick = 1'b1; step(); step(); slowTick = 1'b0;
    chk(rstOut == 1'b1, "R9 still in delay", rstOut, 1);
    pinRstN = 1'b0; step();
    pinRstN = 1'b1;
    measure(1, lat);
    chk(lat == D1, "R9 pin restart delay", lat, D1);

    // R9: restart by the watchdog during a slow count
    pinRstN = 1'b0; step();
    pinRstN = 1'b1;
    slowTick = 1'b1; step(); step(); slowTick = 1'b0;
    wdtExpire = 1'b1; step();
    wdtExpire = 1'b0;
    measure(1, lat);
    chk(lat == D1, "R9 watchdog restart delay", lat, D1);

    // R10: stays released with ticks and setting changes
    begin
      int highs = 0;
      for (int k = 0; k < 40; k++) begin
        slowTick = k[0];
        startSel = 2'(k / 10);
        step();
        if (rstOut) highs++;
      end
      slowTick = 1'b0;
      chk(highs == 0, "R10 reset stays released", highs, 0);
    end

    // R8 R6 R7: flag sequence
    clearPulse(2'b01);
    chk(porFlag == 1'b0 && extFlag == 1'b1, "R8 clear porFlag", {porFlag, extFlag}, 1);
    clearPulse(2'b10);
    chk(porFlag == 1'b0 && extFlag == 1'b0, "R8 clear extFlag", {porFlag, extFlag}, 0);
    startSel = 2'b00;
    wdtExpire = 1'b1; step(); wdtExpire = 1'b0;
    chk(porFlag == 1'b0 && extFlag == 1'b0, "R7 watchdog leaves cleared flags", {porFlag, extFlag}, 0);
    measure(1, lat);
    pinRstN = 1'b0; step(); pinRstN = 1'b1;
    chk(porFlag == 1'b0 && extFlag == 1'b1, "R6 pin keeps porFlag 0", {porFlag, extFlag}, 1);
    measure(1, lat);
    clearPulse(2'b10);
    pinRstN = 1'b0;
    clearPulse(2'b10);
    pinRstN = 1'b1;
    chk(extFlag == 1'b1, "R8 pin wins over clear", extFlag, 1);
    measure(1, lat);

    // R1: a second power-on resets flags
    powerOnIn = 1'b1; step();
    chk(porFlag == 1'b1 && extFlag == 1'b0 && rstOut == 1'b1, "R1 second power-on",
        {rstOut, porFlag, extFlag}, 6);
    powerOnIn = 1'b0;
    measure(1, lat);
    chk(lat == CpuD, "R1 delay after second power-on", lat, CpuD);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule